// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block is the supervisory state machine of a digital phase-locked loop. It watches one qualification flag per reference input and a phase-lock indication from the loop. From these it chooses one of four operating modes: free-run, lock acquisition, locked and holdover. It also chooses which reference the loop tracks. A manual override can force any mode in place of the automatic sequence.

While the loop is locked, the block keeps an exponential moving average of the loop's signed frequency control word. When every reference is lost and that history is valid, the block enters holdover. It raises a source-select output so that the oscillator is steered by the frozen average and not by the live loop. With no valid history it falls back to free-run, where the oscillator runs uncorrected.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After reset the mode is free-run (code 0), the selected reference is 0, the holdover select is low, the history-valid flag is low and the held word is 0.
- R2: In free-run, the mode becomes lock acquisition (code 1) on the next clock once any reference is qualified. With no reference qualified the mode stays free-run, whatever the phase-lock indication.
- R3: In lock acquisition, the mode becomes locked (code 2) on the next clock when phase lock is indicated and the selected reference is still qualified.
- R4: While the selected reference stays qualified, the selection does not change. When it is not qualified and another reference is, the lowest-index qualified reference is selected on the next clock.
- R5: In locked mode, if the selected reference loses qualification while another reference is qualified, the mode returns to lock acquisition on the lowest-index qualified reference.
- R6: If no reference is qualified in locked or acquisition mode, the mode becomes holdover (code 3) when history is valid, and free-run otherwise.
- R7: In holdover, the mode becomes lock acquisition on the next clock once any reference is qualified.
- R8: In locked mode, each update strobe updates the average. The first update loads the word directly. Later updates add the difference (word minus average), arithmetically shifted right by 6.
- R9: The history-valid flag rises after 64 updates and stays set until reset.
- R10: In holdover, the holdover select is high and the held word does not change, even when update strobes arrive.
- R11: While the force enable is high, the mode on the next clock equals the 2-bit forced mode field, using the codes given above.
- R12: On the clock after the force enable is cleared, the mode becomes holdover if history is valid and free-run otherwise. The automatic sequence then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok_i | input | NREF | Per-reference qualification flags |
| phase_locked_i | input | 1 | Loop reports phase lock on the selected reference |
| fcw_i | input | FW | Signed frequency control word from the loop filter |
| fcw_stb_i | input | 1 | Update strobe for fcw_i |
| force_en_i | input | 1 | Manual mode override enable |
| force_mode_i | input | 2 | Forced mode code |
| mode_o | output | 2 | Current mode: 0 free-run, 1 acquisition, 2 locked, 3 holdover |
| ref_sel_o | output | clog2(NREF) | Selected reference index |
| use_hold_o | output | 1 | High when the oscillator is to use the held word |
| hold_fcw_o | output | FW | Averaged frequency word |
| hist_valid_o | output | 1 | History holds at least 64 updates |

## Verification
Assertions check on every cycle that the selection stays put while its reference is qualified, and that a forced mode appears one clock later. They also check that the automatic machine never enters holdover without valid history, that the held word is frozen in holdover, and that the history flag never drops. Only the bench scenarios can show the correct choice of target in each transition, the lowest-index choice on failover, and the numeric values of the average, including its seeding and negative steps. The fallback target after a force release is also covered by the scenarios alone.

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl #(
  parameter int NREF      = 4,
  parameter int FW        = 24,
  parameter int SHIFT     = 6,
  parameter int VALID_CNT = 64,
  localparam int SW = (NREF > 1) ? $clog2(NREF) : 1,
  localparam int CW = $clog2(VALID_CNT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREF-1:0]      ref_ok_i,
  input  logic                 phase_locked_i,
  input  logic signed [FW-1:0] fcw_i,
  input  logic                 fcw_stb_i,
  input  logic                 force_en_i,
  input  logic [1:0]           force_mode_i,
  output logic [1:0]           mode_o,
  output logic [SW-1:0]        ref_sel_o,
  output logic                 use_hold_o,
  output logic [FW-1:0]        hold_fcw_o,
  output logic                 hist_valid_o
);
  typedef enum logic [1:0] {FREE = 2'd0, ACQ = 2'd1, LOCK = 2'd2, HOLD = 2'd3} mode_t;

  mode_t               mode_q, auto_nxt, mode_nxt, fallback;
  logic [SW-1:0]       sel_q, low, sel_nxt;
  logic                force_q;
  logic signed [FW-1:0] avg_q;
  logic [CW-1:0]       cnt_q;
  logic                any_ok, cur_ok, upd, hist_valid;
  logic signed [FW:0]  diff, step;

  always_comb begin
    low = '0;
    for (int i = NREF - 1; i >= 0; i--)
      if (ref_ok_i[i]) low = SW'(i);
  end

  assign any_ok     = |ref_ok_i;
  assign cur_ok     = ref_ok_i[sel_q];
  assign sel_nxt    = (!cur_ok && any_ok) ? low : sel_q;
  assign hist_valid = (cnt_q == CW'(VALID_CNT));
  assign fallback   = hist_valid ? HOLD : FREE;

  always_comb begin
    case (mode_q)
      FREE:    auto_nxt = any_ok ? ACQ : FREE;
      ACQ:     auto_nxt = !cur_ok ? (any_ok ? ACQ : fallback) : (phase_locked_i ? LOCK : ACQ);
      LOCK:    auto_nxt = !cur_ok ? (any_ok ? ACQ : fallback) : LOCK;
      default: auto_nxt = any_ok ? ACQ : HOLD;
    endcase
  end

  assign mode_nxt = force_en_i ? mode_t'(force_mode_i) : (force_q ? fallback : auto_nxt);

  assign upd  = (mode_q == LOCK) && fcw_stb_i;
  assign diff = {fcw_i[FW-1], fcw_i} - {avg_q[FW-1], avg_q};
  assign step = diff >>> SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= FREE;
      sel_q   <= '0;
      force_q <= 1'b0;
      avg_q   <= '0;
      cnt_q   <= '0;
    end else begin
      mode_q  <= mode_nxt;
      sel_q   <= sel_nxt;
      force_q <= force_en_i;
      if (upd) begin
        avg_q <= (cnt_q == '0) ? fcw_i : avg_q + step[FW-1:0];
        if (!hist_valid) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mode_o       = mode_q;
  assign ref_sel_o    = sel_q;
  assign use_hold_o   = (mode_q == HOLD);
  assign hold_fcw_o   = avg_q;
  assign hist_valid_o = hist_valid;

  assert_sticky_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ok_i[ref_sel_o] |=> $stable(ref_sel_o));

  assert_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
    force_en_i |=> (mode_o == $past(force_mode_i)));

  assert_hold_needs_hist_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en_i && !force_q && mode_o != 2'd3) |=> (mode_o != 2'd3 || hist_valid_o));

  assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |=> (mode_o != 2'd3 || $stable(hold_fcw_o)));

  assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(hist_valid_o));

  assert_free_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en_i && !force_q && mode_o == 2'd0) |=> (mode_o == 2'd0 || mode_o == 2'd1));
endmodule

// File: tb/dpll_mode_ctrl_tb_top.sv
module dpll_mode_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ref_ok = '0;
  logic phase_locked = 1'b0, fcw_stb = 1'b0, force_en = 1'b0;
  logic [1:0] force_mode = '0;
  logic signed [23:0] fcw = '0;
  logic [1:0] mode, sel;
  logic use_hold, hist_valid;
  logic [23:0] hold_fcw;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dpll_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ref_ok_i(ref_ok), .phase_locked_i(phase_locked),
    .fcw_i(fcw), .fcw_stb_i(fcw_stb), .force_en_i(force_en), .force_mode_i(force_mode),
    .mode_o(mode), .ref_sel_o(sel), .use_hold_o(use_hold), .hold_fcw_o(hold_fcw),
    .hist_valid_o(hist_valid));

  // {ref_ok[3:0], phase_locked, expected mode[1:0], expected sel[1:0]}
  localparam logic [8:0] VEC [12] = '{
    {4'b0000, 1'b0, 2'd0, 2'd0},  // R2 stay free
    {4'b0000, 1'b1, 2'd0, 2'd0},  // R2 lock flag ignored in free-run
    {4'b0100, 1'b0, 2'd1, 2'd2},  // R2 R4
    {4'b0110, 1'b0, 2'd1, 2'd2},  // R4 sticky
    {4'b0110, 1'b1, 2'd2, 2'd2},  // R3
    {4'b0011, 1'b1, 2'd1, 2'd0},  // R5 failover to lowest
    {4'b0011, 1'b1, 2'd2, 2'd0},  // R3
    {4'b0000, 1'b1, 2'd0, 2'd0},  // R6 no history -> free
    {4'b1000, 1'b0, 2'd1, 2'd3},  // R2 R4
    {4'b1000, 1'b1, 2'd2, 2'd3},  // R3
    {4'b1001, 1'b1, 2'd2, 2'd3},  // R4 keep current
    {4'b1001, 1'b0, 2'd2, 2'd3}   // locked holds without lock flag
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_ok = '0; phase_locked = 1'b0; fcw_stb = 1'b0;
    force_en = 1'b0; force_mode = '0; fcw = '0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    cyc();
    chk("R1 mode", mode, 0); chk("R1 sel", sel, 0); chk("R1 use_hold", use_hold, 0);
    chk("R1 hist_valid", hist_valid, 0); chk("R1 hold_fcw", hold_fcw, 0);

    foreach (VEC[i]) begin
      ref_ok = VEC[i][8:5]; phase_locked = VEC[i][4];
      cyc();
      chk($sformatf("R2-R6 vec%0d mode", i), mode, VEC[i][3:2]);
      chk($sformatf("R4 vec%0d sel", i), sel, VEC[i][1:0]);
    end

    do_reset();
    ref_ok = 4'b0001; phase_locked = 1'b1;
    cyc(2);
    chk("R3 locked", mode, 2);
    fcw = 24'sd1000; fcw_stb = 1'b1;
    cyc(63);
    chk("R9 not yet valid", hist_valid, 0);
    chk("R8 seeded", hold_fcw, 1000);
    cyc();
    chk("R9 valid at 64", hist_valid, 1);
    fcw = 24'sd7400; cyc();
    chk("R8 step up", hold_fcw, 1100);
    fcw = 24'sd460; cyc();
    chk("R8 step down", $signed(hold_fcw), 1090);
    fcw_stb = 1'b0; ref_ok = '0;
    cyc();
    chk("R6 holdover", mode, 3); chk("R10 use_hold", use_hold, 1);
    fcw = -24'sd5000; fcw_stb = 1'b1;
    cyc();
    chk("R10 frozen", hold_fcw, 1090); chk("R10 still hold", mode, 3);
    fcw_stb = 1'b0; ref_ok = 4'b0010;
    cyc();
    chk("R7 acquire", mode, 1); chk("R7 sel", sel, 1);
    chk("R9 still valid", hist_valid, 1);

    ref_ok = '0; force_en = 1'b1; force_mode = 2'd2;
    cyc();
    chk("R11 forced lock", mode, 2);
    force_mode = 2'd0; cyc();
    chk("R11 forced free", mode, 0);
    force_en = 1'b0; cyc();
    chk("R12 release valid -> hold", mode, 3);
    ref_ok = 4'b0100; cyc();
    chk("R12 auto resumes", mode, 1);

    do_reset();
    force_en = 1'b1; force_mode = 2'd2;
    cyc();
    chk("R11 forced lock", mode, 2);
    force_en = 1'b0; cyc();
    chk("R12 release no history -> free", mode, 0);
    chk("R1 hist cleared", hist_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule